// File: doc/BRIEF.md
# Tile Accumulate Write-Back Buffer

The block collects partial results from a compute array into a two-dimensional word store organised as 4x4 tiles. Each clock cycle it can take one tile of sixteen signed fixed-point values together with a tile index. Depending on a mode bit, it either replaces the stored tile or adds the new values into it. The addition saturates at the limits of the word width. Updates are accepted at a sustained rate of one per cycle, including back-to-back updates to the same tile.

Once the producer has finished accumulating, it raises a flush request. The buffer then streams every stored word to an external memory port over a valid/ready handshake, each word paired with its row-major word address. While the drain is running the buffer refuses further work. After a flush, and after reset, the first update to each tile behaves as an overwrite, so the next accumulation round starts from clean values without a separate clearing pass.

The store is split into sixteen dual-port banks, one for each position inside a tile. A tile therefore occupies a single address in every bank, and its read-modify-write takes one read cycle and one write cycle.

Top module: `tile_accum_buf`

## Requirements
- R1: With `upd_acc` low, an accepted update stores the sixteen lane values unchanged. Lane i of `upd_data` sits at bits [i*DATA_W +: DATA_W] and maps to row i/4, column i%4 of the tile.
- R2: With `upd_acc` high, an accepted update adds each lane value to the stored word as signed two's-complement numbers.
- R3: A sum above the largest representable value stores that largest value. A sum below the smallest representable value stores that smallest value.
- R4: While not busy, `upd_ready` stays high and an update is accepted every cycle `upd_valid` is high. Consecutive updates to the same tile accumulate correctly with no gap between them.
- R5: After reset, and after each completed flush, the first accepted update to a tile acts as an overwrite even when `upd_acc` is high.
- R6: A `flush_req` seen while idle raises `busy` in the next cycle. `busy` stays high until the cycle after the last word is accepted downstream.
- R7: A flush emits every word exactly once. Tiles are emitted in ascending index order, and lanes 0 to 15 in order within each tile. Tile t covers rows 4*(t / (COLS/4)) onward and columns 4*(t % (COLS/4)) onward. `out_addr` equals row*COLS+col.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_addr` hold their values.
- R9: While `busy` is high, `upd_ready` is low, tile updates are ignored, and further `flush_req` pulses are ignored.
- R10: A flush leaves the stored contents unchanged, so a second flush with no updates in between emits the same words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | Tile update present |
| upd_acc | input | 1 | 1 = add into stored tile, 0 = overwrite |
| upd_tile | input | TILE_AW | Tile index of the update |
| upd_data | input | 16*DATA_W | Sixteen signed lane values |
| upd_ready | output | 1 | Update can be accepted (not busy) |
| flush_req | input | 1 | Start draining the store |
| busy | output | 1 | Drain in progress |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the word |
| out_addr | output | WORD_AW | Row-major word address |
| out_data | output | DATA_W | Word value |

## Verification
The bench issues updates to the same tile in consecutive cycles. A design with no bypass of the just-written value would lose one of the two additions. It drives lane values toward both ends of the range: a design that wraps instead of clamping would return values of the opposite sign. It sends accumulate updates as the first touch after reset and after a flush. A design with no first-write flag would add into stale data. During a drain it toggles `out_ready` at random and pushes both updates and further flush requests. A design that misordered the stream, dropped or repeated words, or let a refused update through would show wrong addresses or data, and a second drain would differ from the first.

// File: rtl/tacc_pkg.sv
package tacc_pkg;
  localparam int LANES  = 16;
  localparam int LANE_W = 4;

  typedef enum logic [1:0] {
    FL_IDLE  = 2'd0,
    FL_GAP   = 2'd1,
    FL_FETCH = 2'd2,
    FL_EMIT  = 2'd3
  } flush_state_e;
endpackage

// File: rtl/tacc_bank.sv
module tacc_bank #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 28,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  // port B: write
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // port A: registered read, returns the value before a same-edge write
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/tacc_lane.sv
module tacc_lane #(
  parameter int DATA_W = 28
) (
  input  logic              overwrite,
  input  logic [DATA_W-1:0] new_val,
  input  logic [DATA_W-1:0] mem_val,
  input  logic              fwd_hit,
  input  logic [DATA_W-1:0] fwd_val,
  output logic [DATA_W-1:0] result
);
  localparam logic [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] old_val;
  logic [DATA_W:0]   sum;

  always_comb begin
    old_val = fwd_hit ? fwd_val : mem_val;
    sum     = {old_val[DATA_W-1], old_val} + {new_val[DATA_W-1], new_val};
    if (overwrite)
      result = new_val;
    else if (sum[DATA_W] != sum[DATA_W-1])
      result = sum[DATA_W] ? MIN_V : MAX_V;
    else
      result = sum[DATA_W-1:0];
  end
endmodule

// File: rtl/tacc_rmw.sv
module tacc_rmw
  import tacc_pkg::*;
#(
  parameter int DATA_W  = 28,
  parameter int TILE_AW = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_over,
  input  logic [TILE_AW-1:0]      in_tile,
  input  logic [LANES*DATA_W-1:0] in_data,
  input  logic [LANES*DATA_W-1:0] rd_data,
  output logic                    wr_en,
  output logic [TILE_AW-1:0]      wr_tile,
  output logic [LANES*DATA_W-1:0] wr_data
);
  logic                    s1_valid_q, s1_valid_d;
  logic                    s1_over_q;
  logic [TILE_AW-1:0]      s1_tile_q;
  logic [LANES*DATA_W-1:0] s1_data_q;
  logic                    fw_valid_q, fw_valid_d;
  logic [TILE_AW-1:0]      fw_tile_q;
  logic [LANES*DATA_W-1:0] fw_data_q;
  logic                    fwd_hit;

  always_comb begin
    s1_valid_d = in_valid;
    fw_valid_d = s1_valid_q;
    fwd_hit    = fw_valid_q && (fw_tile_q == s1_tile_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      fw_valid_q <= 1'b0;
    end else begin
      s1_valid_q <= s1_valid_d;
      fw_valid_q <= fw_valid_d;
    end
  end

  // payload registers with explicit clock enables
  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_over_q <= in_over;
      s1_tile_q <= in_tile;
      s1_data_q <= in_data;
    end
    if (s1_valid_q) begin
      fw_tile_q <= s1_tile_q;
      fw_data_q <= wr_data;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tacc_lane #(.DATA_W(DATA_W)) u_lane (
      .overwrite (s1_over_q),
      .new_val   (s1_data_q[g*DATA_W +: DATA_W]),
      .mem_val   (rd_data[g*DATA_W +: DATA_W]),
      .fwd_hit   (fwd_hit),
      .fwd_val   (fw_data_q[g*DATA_W +: DATA_W]),
      .result    (wr_data[g*DATA_W +: DATA_W])
    );
  end

  assign wr_en   = s1_valid_q;
  assign wr_tile = s1_tile_q;
endmodule

// File: rtl/tacc_flush.sv
module tacc_flush
  import tacc_pkg::*;
#(
  parameter int NTILES  = 256,
  localparam int TILE_AW = $clog2(NTILES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               out_ready,
  output logic               busy,
  output logic               rd_en,
  output logic [TILE_AW-1:0] rd_tile,
  output logic [LANE_W-1:0]  lane,
  output logic               out_valid,
  output logic               done
);
  localparam logic [TILE_AW-1:0] LAST_TILE = TILE_AW'(NTILES - 1);
  localparam logic [LANE_W-1:0]  LAST_LANE = LANE_W'(LANES - 1);

  flush_state_e        state_q, state_d;
  logic [TILE_AW-1:0]  tile_q, tile_d;
  logic [LANE_W-1:0]   lane_q, lane_d;

  always_comb begin
    state_d   = state_q;
    tile_d    = tile_q;
    lane_d    = lane_q;
    rd_en     = 1'b0;
    out_valid = 1'b0;
    done      = 1'b0;
    case (state_q)
      FL_IDLE: begin
        if (start) begin
          state_d = FL_GAP;
          tile_d  = '0;
          lane_d  = '0;
        end
      end
      FL_GAP:   state_d = FL_FETCH;
      FL_FETCH: begin
        rd_en   = 1'b1;
        state_d = FL_EMIT;
      end
      FL_EMIT: begin
        out_valid = 1'b1;
        if (out_ready) begin
          if (lane_q == LAST_LANE) begin
            lane_d = '0;
            if (tile_q == LAST_TILE) begin
              state_d = FL_IDLE;
              done    = 1'b1;
            end else begin
              tile_d  = tile_q + 1'b1;
              state_d = FL_FETCH;
            end
          end else begin
            lane_d = lane_q + 1'b1;
          end
        end
      end
      default: state_d = FL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FL_IDLE;
      tile_q  <= '0;
      lane_q  <= '0;
    end else begin
      state_q <= state_d;
      tile_q  <= tile_d;
      lane_q  <= lane_d;
    end
  end

  assign busy    = (state_q != FL_IDLE);
  assign rd_tile = tile_q;
  assign lane    = lane_q;
endmodule

// File: rtl/tile_accum_buf.sv
module tile_accum_buf
  import tacc_pkg::*;
#(
  parameter int ROWS   = 64,
  parameter int COLS   = 64,
  parameter int DATA_W = 28,
  localparam int TR_W    = $clog2(ROWS / 4),
  localparam int TC_W    = $clog2(COLS / 4),
  localparam int NTILES  = (ROWS / 4) * (COLS / 4),
  localparam int TILE_AW = TR_W + TC_W,
  localparam int WORD_AW = TILE_AW + LANE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd_valid,
  input  logic                    upd_acc,
  input  logic [TILE_AW-1:0]      upd_tile,
  input  logic [LANES*DATA_W-1:0] upd_data,
  output logic                    upd_ready,
  input  logic                    flush_req,
  output logic                    busy,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [WORD_AW-1:0]      out_addr,
  output logic [DATA_W-1:0]       out_data
);
  logic                    accept;
  logic                    upd_over;
  logic [NTILES-1:0]       first_q, first_d;
  logic                    fl_rd_en, fl_done;
  logic [TILE_AW-1:0]      fl_tile;
  logic [LANE_W-1:0]       fl_lane;
  logic                    bank_rd_en;
  logic [TILE_AW-1:0]      bank_rd_addr;
  logic [LANES*DATA_W-1:0] bank_q;
  logic                    wr_en;
  logic [TILE_AW-1:0]      wr_tile;
  logic [LANES*DATA_W-1:0] wr_data;

  always_comb begin
    accept       = upd_valid && !busy;
    upd_over     = !upd_acc || first_q[upd_tile];
    bank_rd_en   = accept || fl_rd_en;
    bank_rd_addr = busy ? fl_tile : upd_tile;
    first_d      = first_q;
    if (fl_done)
      first_d = '1;
    else if (accept)
      first_d[upd_tile] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) first_q <= '1;
    else        first_q <= first_d;
  end

  tacc_flush #(.NTILES(NTILES)) u_flush (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (flush_req),
    .out_ready (out_ready),
    .busy      (busy),
    .rd_en     (fl_rd_en),
    .rd_tile   (fl_tile),
    .lane      (fl_lane),
    .out_valid (out_valid),
    .done      (fl_done)
  );

  tacc_rmw #(.DATA_W(DATA_W), .TILE_AW(TILE_AW)) u_rmw (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (accept),
    .in_over  (upd_over),
    .in_tile  (upd_tile),
    .in_data  (upd_data),
    .rd_data  (bank_q),
    .wr_en    (wr_en),
    .wr_tile  (wr_tile),
    .wr_data  (wr_data)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    tacc_bank #(.DEPTH(NTILES), .DATA_W(DATA_W)) u_bank (
      .clk     (clk),
      .rd_en   (bank_rd_en),
      .rd_addr (bank_rd_addr),
      .rd_data (bank_q[b*DATA_W +: DATA_W]),
      .wr_en   (wr_en),
      .wr_addr (wr_tile),
      .wr_data (wr_data[b*DATA_W +: DATA_W])
    );
  end

  assign upd_ready = !busy;
  assign out_data  = bank_q[fl_lane*DATA_W +: DATA_W];
  assign out_addr  = {fl_tile[TILE_AW-1:TC_W], fl_lane[3:2], fl_tile[TC_W-1:0], fl_lane[1:0]};
endmodule

// File: rtl/tile_accum_buf_chk.sv
module tile_accum_buf_chk #(
  parameter int DATA_W  = 28,
  parameter int WORD_AW = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush_req,
  input logic               busy,
  input logic               out_valid,
  input logic               out_ready,
  input logic [WORD_AW-1:0] out_addr,
  input logic [DATA_W-1:0]  out_data,
  input logic               wr_valid
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_addr));

  assert_flush_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req && !busy |=> busy);

  assert_busy_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(out_valid && out_ready));

  assert_valid_in_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);

  assert_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> !wr_valid);
endmodule

bind tile_accum_buf tile_accum_buf_chk #(.DATA_W(DATA_W), .WORD_AW(WORD_AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush_req (flush_req),
  .busy      (busy),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_addr  (out_addr),
  .out_data  (out_data),
  .wr_valid  (wr_en)
);

// File: tb/tile_accum_buf_bench.sv
module tile_accum_buf_bench;
  localparam int ROWS = 16, COLS = 16, W = 12;
  localparam int TC = COLS / 4, NT = (ROWS / 4) * (COLS / 4), NW = ROWS * COLS;
  localparam int TAW = 4, WAW = 8;

  logic clk = 0, rst_n;
  logic upd_valid, upd_acc, upd_ready, flush_req, busy, out_valid, out_ready;
  logic [TAW-1:0] upd_tile;
  logic [16*W-1:0] upd_data;
  logic [WAW-1:0] out_addr;
  logic [W-1:0] out_data;

  int model [NW];
  bit first [NT];
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tile_accum_buf #(.ROWS(ROWS), .COLS(COLS), .DATA_W(W)) u_tile_accum_buf (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_acc(upd_acc),
    .upd_tile(upd_tile), .upd_data(upd_data), .upd_ready(upd_ready),
    .flush_req(flush_req), .busy(busy), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_data(out_data));

  function automatic int f_addr(int t, int e);
    return ((t / TC) * 4 + e / 4) * COLS + (t % TC) * 4 + e % 4;
  endfunction

  function automatic int f_sat(int v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  function automatic int sx(logic [W-1:0] x);
    return x[W-1] ? int'(x) - 4096 : int'(x);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // one cycle of update stimulus; model follows acceptance seen at the port
  task automatic step(bit v, bit acc, int t, logic [16*W-1:0] d);
    @(negedge clk);
    upd_valid = v; upd_acc = acc; upd_tile = TAW'(t); upd_data = d;
    if (v && upd_ready) begin
      for (int e = 0; e < 16; e++) begin
        int a = f_addr(t, e);
        int nv = sx(d[e*W +: W]);
        if (!acc || first[t]) model[a] = nv;
        else model[a] = f_sat(model[a] + nv);
      end
      first[t] = 0;
    end
  endtask

  function automatic logic [16*W-1:0] fill(int v);
    logic [16*W-1:0] d;
    for (int e = 0; e < 16; e++) d[e*W +: W] = W'(v);
    return d;
  endfunction

  function automatic logic [16*W-1:0] rnd_tile();
    logic [16*W-1:0] d;
    for (int e = 0; e < 16; e++) begin
      case ($urandom % 4)
        0: d[e*W +: W] = W'(2047 - ($urandom % 64));
        1: d[e*W +: W] = W'(-2048 + ($urandom % 64));
        default: d[e*W +: W] = W'($urandom);
      endcase
    end
    return d;
  endfunction

  // drain and compare against the model; optionally inject refused stimulus
  task automatic do_flush(bit inject);
    int k = 0;
    @(negedge clk);
    upd_valid = 0; flush_req = 1; out_ready = 0;
    @(negedge clk);
    flush_req = 0;
    chk(busy == 1, "R6 busy after flush_req", busy, 1);
    while (k < NW) begin
      @(negedge clk);
      out_ready = ($urandom % 4) != 0;
      if (inject) begin
        upd_valid = $urandom % 2; upd_acc = 0; upd_tile = TAW'($urandom);
        upd_data = fill(777); flush_req = $urandom % 2;
        chk(upd_ready == 0, "R9 upd_ready low while busy", upd_ready, 0);
      end
      if (out_valid && out_ready) begin
        int t = k / 16, e = k % 16;
        chk(int'(out_addr) == f_addr(t, e), "R7 address order", out_addr, f_addr(t, e));
        chk(sx(out_data) == model[f_addr(t, e)], "R1/R2/R3/R5 word value",
            sx(out_data), model[f_addr(t, e)]);
        k++;
      end
    end
    @(negedge clk);
    upd_valid = 0; flush_req = 0; out_ready = 0;
    chk(busy == 0, "R6 busy cleared after last word", busy, 0);
    chk(out_valid == 0, "R6 no output when idle", out_valid, 0);
    for (int t = 0; t < NT; t++) first[t] = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R6 actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed1));
    rst_n = 0; upd_valid = 0; upd_acc = 0; upd_tile = '0; upd_data = '0;
    flush_req = 0; out_ready = 0;
    for (int t = 0; t < NT; t++) first[t] = 1;
    repeat (3) @(negedge clk);
    chk(busy == 0, "R6 reset busy", busy, 0);
    chk(out_valid == 0, "R6 reset out_valid", out_valid, 0);
    chk(upd_ready == 1, "R4 reset upd_ready", upd_ready, 1);
    rst_n = 1;

    // R5: accumulate as first touch after reset overwrites; R4 back-to-back
    for (int t = 0; t < NT; t++) step(1, 1, t, rnd_tile());
    // R4: same tile every cycle, forwarding path
    step(1, 0, 2, fill(10));
    step(1, 1, 2, fill(5));
    step(1, 1, 2, fill(-3));
    step(1, 1, 2, fill(100));
    // R3: positive and negative saturation, chained
    step(1, 0, 5, fill(2000));
    step(1, 1, 5, fill(2000));
    step(1, 1, 5, fill(-1));
    step(1, 0, 6, fill(-2000));
    step(1, 1, 6, fill(-2000));
    step(1, 1, 7, fill(1));
    chk(upd_ready == 1, "R4 ready during stream", upd_ready, 1);
    // random mix on few tiles for collisions
    for (int i = 0; i < 300; i++)
      step($urandom % 4 != 0, $urandom % 4 != 0, $urandom % 4, rnd_tile());
    step(0, 0, 0, '0);
    do_flush(1);   // R9 injection during drain
    do_flush(0);   // R10 second drain identical
    // R5 after flush: accumulate mode on every tile overwrites
    for (int i = 0; i < NT; i++) step(1, 1, i, rnd_tile());
    for (int i = 0; i < 200; i++)
      step($urandom % 3 != 0, $urandom % 2, $urandom % NT, rnd_tile());
    step(0, 0, 0, '0);
    do_flush(0);
    finish_run();
  end
endmodule